// File: doc/BRIEF.md
# Tiled Surface Layout Calculator

This block works out the memory layout of a two-dimensionally tiled colour surface. It takes the surface size in pixels, the bytes per sample, the samples per pixel, the number of memory pipes and banks, and the bank width and height factors. From these it derives the tile-split size, the macro-tile aspect, the macro-tile shape counted in 8x8-pixel micro-tiles, the padded surface size, the row pitch and the total byte size. Allocation code or a command builder uses it to size and align buffers before it programs a render target.

Every count except the pixel dimensions is a power of two and arrives as its base-2 logarithm. This lets the block do the square roots and divisions with adds and shifts. A short multi-cycle sequence sits behind a start/done handshake, and a serial shift-add multiplier forms the area product. The results stay on registered outputs until the next accepted start.

Top module: `tsl_layout_calc`

## Requirements
- R1: A start seen while the block is idle raises busy on the next cycle. Done is a pulse exactly one cycle long. It comes no more than ALN_W+4 cycles after the start (ALN_W = DIM_W+1), and busy is low in the cycle done is high.
- R2: After reset, busy, done and every result output are zero.
- R3: The micro-tile size is 64 × 2^bps_lg × 2^spp_lg bytes. If it is strictly greater than 1024, tile_split = 128 × 2^bps_lg. Otherwise, and this includes exactly 1024, tile_split = 1024.
- R4: The bank ratio is (2^banks_lg × 2^bankh_lg) / (2^pipes_lg × 2^bankw_lg). aspect_lg is floor(log2(ratio) / 2). A ratio below 1 gives aspect_lg = 0.
- R5: Let count = 2^(pipes_lg+banks_lg+bankw_lg+bankh_lg). mtw_lg is the smallest w with 2^(2w+aspect_lg) ≥ count, and mth_lg = log2(count) − mtw_lg.
- R6: aligned_w is surf_w rounded up to a multiple of 8 × 2^mtw_lg. aligned_h is surf_h rounded up to a multiple of 8 × 2^mth_lg.
- R7: pitch = aligned_w × 2^(bps_lg+spp_lg) bytes.
- R8: total_size = aligned_w × aligned_h × 2^(bps_lg+spp_lg), taken modulo 2^SIZE_W.
- R9: From the done pulse until the next accepted start, all result outputs hold their values, whatever happens on the configuration inputs.
- R10: A start pulse while busy is high is ignored. The calculation in flight completes with the inputs sampled at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a calculation (accepted only when idle) |
| surf_w | input | DIM_W | Surface width in pixels |
| surf_h | input | DIM_W | Surface height in pixels |
| bps_lg | input | LF | log2 of bytes per sample |
| spp_lg | input | LF | log2 of samples per pixel |
| pipes_lg | input | LF | log2 of pipe count |
| banks_lg | input | LF | log2 of bank count |
| bankw_lg | input | LF | log2 of bank width factor |
| bankh_lg | input | LF | log2 of bank height factor |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| tile_split | output | SPLIT_W | Tile-split size in bytes |
| aspect_lg | output | 5 | log2 of macro-tile aspect |
| mtw_lg | output | 5 | log2 of macro-tile width in micro-tiles |
| mth_lg | output | 5 | log2 of macro-tile height in micro-tiles |
| aligned_w | output | DIM_W+1 | Padded width in pixels |
| aligned_h | output | DIM_W+1 | Padded height in pixels |
| pitch | output | SIZE_W | Row pitch in bytes |
| total_size | output | SIZE_W | Surface size in bytes |

## Verification
The main calculation is run with three related surfaces of the same size: an 8-sample 4-byte target, its 1-sample mask companion, and a point-sampled target with double bank height. The first two separate the tile-split override from the default split. The third separates a change of macro-tile height from a change of width. Further vectors place the micro-tile at exactly 1024 bytes, which must keep the default split. Others use more pipes than banks, which must clamp the aspect to zero, and an odd pipe-bank count, where width and height differ by one. A 1x1 surface shows that rounding is upward. A start pulsed during a busy run, and input changes made after done with no start, show whether the outputs hold their results or follow the inputs.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
   // Every log2 quantity the block produces fits this width.
   localparam int unsigned LG_W         = 5;
   // A micro-tile is 8x8 pixels: 2^3 per side, 2^6 pixels.
   localparam int unsigned UT_SIDE_LG   = 3;
   localparam int unsigned UT_PIX_LG    = 6;
   // Default tile-split in bytes, as log2 (1024).
   localparam int unsigned DEF_SPLIT_LG = 10;

   typedef struct packed {
      logic [LG_W-1:0] split_lg;
      logic [LG_W-1:0] aspect_lg;
      logic [LG_W-1:0] mtw_lg;
      logic [LG_W-1:0] mth_lg;
   } tsl_shape_t;
endpackage

// File: rtl/tsl_shape.sv
module tsl_shape
   import tsl_pkg::*;
#(
   parameter int unsigned LF = 3
) (
   input  logic [LF-1:0] bps_lg,
   input  logic [LF-1:0] spp_lg,
   input  logic [LF-1:0] pipes_lg,
   input  logic [LF-1:0] banks_lg,
   input  logic [LF-1:0] bankw_lg,
   input  logic [LF-1:0] bankh_lg,
   output tsl_shape_t    shape
);
   logic [LG_W-1:0] ut_bytes_lg;
   logic [LG_W-1:0] across_lg;
   logic [LG_W-1:0] down_lg;
   logic [LG_W-1:0] ratio_lg;
   logic [LG_W-1:0] count_lg;
   logic [LG_W-1:0] asp_lg;
   logic [LG_W-1:0] wid_lg;

   always_comb begin
      ut_bytes_lg = LG_W'(UT_PIX_LG) + LG_W'(bps_lg) + LG_W'(spp_lg);
      across_lg   = LG_W'(pipes_lg) + LG_W'(bankw_lg);
      down_lg     = LG_W'(banks_lg) + LG_W'(bankh_lg);
      // ratio below one clamps to one
      ratio_lg    = (down_lg > across_lg) ? (down_lg - across_lg) : '0;
      count_lg    = across_lg + down_lg;
      // floor of half the log: square root taken down to a power of two
      asp_lg      = ratio_lg >> 1;
      // ceiling of half of (count / aspect)
      wid_lg      = (count_lg > asp_lg) ? ((count_lg - asp_lg + LG_W'(1)) >> 1) : '0;

      shape.split_lg  = (ut_bytes_lg > LG_W'(DEF_SPLIT_LG))
                      ? (LG_W'(UT_PIX_LG + 1) + LG_W'(bps_lg))
                      : LG_W'(DEF_SPLIT_LG);
      shape.aspect_lg = asp_lg;
      shape.mtw_lg    = wid_lg;
      shape.mth_lg    = count_lg - wid_lg;
   end
endmodule

// File: rtl/tsl_align.sv
module tsl_align
   import tsl_pkg::*;
#(
   parameter int unsigned DIM_W = 14,
   parameter int unsigned OUT_W = 15
) (
   input  logic [DIM_W-1:0] dim,
   input  logic [LG_W-1:0]  mt_lg,
   output logic [OUT_W-1:0] aligned
);
   logic [OUT_W-1:0] mask;

   always_comb begin
      mask    = (OUT_W'(1) << (mt_lg + LG_W'(UT_SIDE_LG))) - OUT_W'(1);
      aligned = (OUT_W'(dim) + mask) & ~mask;
   end
endmodule

// File: rtl/tsl_mult.sv
module tsl_mult #(
   parameter int unsigned A_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [A_W-1:0]   a,
   input  logic [A_W-1:0]   b,
   output logic [2*A_W-1:0] prod,
   output logic             valid
);
   localparam int unsigned P_W   = 2 * A_W;
   localparam int unsigned CNT_W = $clog2(A_W + 1);

   logic [P_W-1:0]   acc;
   logic [P_W-1:0]   mcand;
   logic [A_W-1:0]   mplier;
   logic [CNT_W-1:0] left;
   logic             run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         mcand  <= '0;
         mplier <= '0;
         left   <= '0;
         run    <= 1'b0;
         valid  <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (load) begin
            acc    <= '0;
            mcand  <= P_W'(a);
            mplier <= b;
            left   <= CNT_W'(A_W);
            run    <= 1'b1;
         end else if (run) begin
            if (mplier[0]) acc <= acc + mcand;
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
            left   <= left - CNT_W'(1);
            if (left == CNT_W'(1)) begin
               run   <= 1'b0;
               valid <= 1'b1;
            end
         end
      end
   end

   assign prod = acc;
endmodule

// File: rtl/tsl_layout_calc.sv
module tsl_layout_calc
   import tsl_pkg::*;
#(
   parameter int unsigned DIM_W   = 14,
   parameter int unsigned LF      = 3,
   parameter int unsigned SIZE_W  = 32,
   parameter int unsigned SPLIT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [DIM_W-1:0]   surf_w,
   input  logic [DIM_W-1:0]   surf_h,
   input  logic [LF-1:0]      bps_lg,
   input  logic [LF-1:0]      spp_lg,
   input  logic [LF-1:0]      pipes_lg,
   input  logic [LF-1:0]      banks_lg,
   input  logic [LF-1:0]      bankw_lg,
   input  logic [LF-1:0]      bankh_lg,
   output logic               busy,
   output logic               done,
   output logic [SPLIT_W-1:0] tile_split,
   output logic [LG_W-1:0]    aspect_lg,
   output logic [LG_W-1:0]    mtw_lg,
   output logic [LG_W-1:0]    mth_lg,
   output logic [DIM_W:0]     aligned_w,
   output logic [DIM_W:0]     aligned_h,
   output logic [SIZE_W-1:0]  pitch,
   output logic [SIZE_W-1:0]  total_size
);
   localparam int unsigned ALN_W = DIM_W + 1;
   localparam int unsigned PRD_W = 2 * ALN_W;
   localparam int unsigned TOT_W = (PRD_W > SIZE_W) ? PRD_W : SIZE_W;

   generate
      if (LF < 1 || LF > 3) begin : g_bad_lf
         $error("LF must be 1..3 so log2 sums fit LG_W");
      end
      if (DIM_W < 4 || SIZE_W <= ALN_W) begin : g_bad_dim
         $error("SIZE_W must exceed DIM_W+1 and DIM_W must be at least 4");
      end
      if (SPLIT_W < (1 << LF) + 8) begin : g_bad_split
         $error("SPLIT_W too narrow for the largest tile-split");
      end
   endgenerate

   typedef enum logic [1:0] {ST_IDLE, ST_SHAPE, ST_MUL} st_e;
   st_e state;

   logic [DIM_W-1:0] w_q, h_q;
   logic [LF-1:0]    bps_q, spp_q, pipes_q, banks_q, bankw_q, bankh_q;
   logic [LG_W-1:0]  bpp_q;

   tsl_shape_t shape;

   tsl_shape #(.LF(LF)) u_shape (
      .bps_lg   (bps_q),
      .spp_lg   (spp_q),
      .pipes_lg (pipes_q),
      .banks_lg (banks_q),
      .bankw_lg (bankw_q),
      .bankh_lg (bankh_q),
      .shape    (shape)
   );

   logic [DIM_W-1:0] dim_v [2];
   logic [LG_W-1:0]  mt_v  [2];
   logic [ALN_W-1:0] aln   [2];

   assign dim_v[0] = w_q;
   assign dim_v[1] = h_q;
   assign mt_v[0]  = shape.mtw_lg;
   assign mt_v[1]  = shape.mth_lg;

   for (genvar d = 0; d < 2; d++) begin : g_axis
      tsl_align #(.DIM_W(DIM_W), .OUT_W(ALN_W)) u_align (
         .dim     (dim_v[d]),
         .mt_lg   (mt_v[d]),
         .aligned (aln[d])
      );
   end

   logic             mul_load;
   logic             mul_valid;
   logic [PRD_W-1:0] mul_prod;

   assign mul_load = (state == ST_SHAPE);

   tsl_mult #(.A_W(ALN_W)) u_mult (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (mul_load),
      .a     (aln[0]),
      .b     (aln[1]),
      .prod  (mul_prod),
      .valid (mul_valid)
   );

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         done       <= 1'b0;
         w_q        <= '0;
         h_q        <= '0;
         bps_q      <= '0;
         spp_q      <= '0;
         pipes_q    <= '0;
         banks_q    <= '0;
         bankw_q    <= '0;
         bankh_q    <= '0;
         bpp_q      <= '0;
         tile_split <= '0;
         aspect_lg  <= '0;
         mtw_lg     <= '0;
         mth_lg     <= '0;
         aligned_w  <= '0;
         aligned_h  <= '0;
         pitch      <= '0;
         total_size <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  w_q     <= surf_w;
                  h_q     <= surf_h;
                  bps_q   <= bps_lg;
                  spp_q   <= spp_lg;
                  pipes_q <= pipes_lg;
                  banks_q <= banks_lg;
                  bankw_q <= bankw_lg;
                  bankh_q <= bankh_lg;
                  bpp_q   <= LG_W'(bps_lg) + LG_W'(spp_lg);
                  state   <= ST_SHAPE;
               end
            end
            ST_SHAPE: begin
               tile_split <= SPLIT_W'(1) << shape.split_lg;
               aspect_lg  <= shape.aspect_lg;
               mtw_lg     <= shape.mtw_lg;
               mth_lg     <= shape.mth_lg;
               aligned_w  <= aln[0];
               aligned_h  <= aln[1];
               pitch      <= SIZE_W'(aln[0]) << bpp_q;
               state      <= ST_MUL;
            end
            ST_MUL: begin
               if (mul_valid) begin
                  total_size <= SIZE_W'(TOT_W'(mul_prod) << bpp_q);
                  done       <= 1'b1;
                  state      <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tsl_layout_chk.sv
module tsl_layout_chk #(
   parameter int unsigned DIM_W   = 14,
   parameter int unsigned SIZE_W  = 32,
   parameter int unsigned SPLIT_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic [SPLIT_W-1:0] tile_split,
   input logic [DIM_W:0]     aligned_w,
   input logic [DIM_W:0]     aligned_h,
   input logic [SIZE_W-1:0]  pitch,
   input logic [SIZE_W-1:0]  total_size
);
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy); // R1

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R1

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R1

   AST_SPLIT_POW2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $onehot(tile_split)); // R3

   AST_ALIGN_MULT8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (aligned_w[2:0] == 3'd0 && aligned_h[2:0] == 3'd0)); // R6

   AST_TOTAL_MULT64: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (total_size[5:0] == 6'd0)); // R8

   AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(total_size) && $stable(pitch) && $stable(aligned_w)
                             && $stable(aligned_h) && $stable(tile_split))); // R9
endmodule

bind tsl_layout_calc tsl_layout_chk #(
   .DIM_W   (DIM_W),
   .SIZE_W  (SIZE_W),
   .SPLIT_W (SPLIT_W)
) u_tsl_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .tile_split (tile_split),
   .aligned_w  (aligned_w),
   .aligned_h  (aligned_h),
   .pitch      (pitch),
   .total_size (total_size)
);

// File: tb/test_tsl_layout_calc.sv
module test_tsl_layout_calc;
   localparam int DIM_W   = 14;
   localparam int LF      = 3;
   localparam int SIZE_W  = 32;
   localparam int SPLIT_W = 16;
   localparam int ALN_W   = DIM_W + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [DIM_W-1:0] surf_w = '0, surf_h = '0;
   logic [LF-1:0] bps_lg = '0, spp_lg = '0, pipes_lg = '0, banks_lg = '0, bankw_lg = '0, bankh_lg = '0;
   logic busy, done;
   logic [SPLIT_W-1:0] tile_split;
   logic [4:0] aspect_lg, mtw_lg, mth_lg;
   logic [DIM_W:0] aligned_w, aligned_h;
   logic [SIZE_W-1:0] pitch, total_size;

   always #5 clk = ~clk;

   tsl_layout_calc #(.DIM_W(DIM_W), .LF(LF), .SIZE_W(SIZE_W), .SPLIT_W(SPLIT_W)) i_tsl_layout_calc (
      .clk(clk), .rst_n(rst_n), .start(start), .surf_w(surf_w), .surf_h(surf_h),
      .bps_lg(bps_lg), .spp_lg(spp_lg), .pipes_lg(pipes_lg), .banks_lg(banks_lg),
      .bankw_lg(bankw_lg), .bankh_lg(bankh_lg), .busy(busy), .done(done),
      .tile_split(tile_split), .aspect_lg(aspect_lg), .mtw_lg(mtw_lg), .mth_lg(mth_lg),
      .aligned_w(aligned_w), .aligned_h(aligned_h), .pitch(pitch), .total_size(total_size)
   );

   int checks = 0;
   int errors = 0;

   // reference model state: results expected on the outputs while idle
   longint e_split, e_asp, e_mtw, e_mth, e_aw, e_ah, e_pitch, e_total;
   longint p_split, p_asp, p_mtw, p_mth, p_aw, p_ah, p_pitch, p_total;
   bit model_ok = 1'b0;
   bit waiting  = 1'b0;

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int lg2(longint v);
      int r = 0;
      while ((longint'(1) << r) < v) r++;
      return r;
   endfunction

   // behavioural prediction from the requirements, in plain integers
   task automatic predict(int w, int h, int bs, int sp, int pi, int ba, int bw, int bh);
      longint bps = longint'(1) << bs, spp = longint'(1) << sp;
      longint utile = 64 * bps * spp;
      longint ratio = ((longint'(1) << ba) * (longint'(1) << bh)) / ((longint'(1) << pi) * (longint'(1) << bw));
      longint count = (longint'(1) << pi) * (longint'(1) << ba) * (longint'(1) << bw) * (longint'(1) << bh);
      longint asp = 1, mw = 1, mh, aw_u, ah_u;
      if (ratio < 1) ratio = 1;
      while ((asp * 2) * (asp * 2) <= ratio) asp = asp * 2;          // R4
      while (mw * mw * asp < count) mw = mw * 2;                      // R5
      mh = count / mw;
      aw_u = 8 * mw;
      ah_u = 8 * mh;
      p_split = (utile > 1024) ? 128 * bps : 1024;                    // R3
      p_asp   = lg2(asp);
      p_mtw   = lg2(mw);
      p_mth   = lg2(mh);
      p_aw    = ((w + aw_u - 1) / aw_u) * aw_u;                       // R6
      p_ah    = ((h + ah_u - 1) / ah_u) * ah_u;
      p_pitch = (p_aw * bps * spp) % (longint'(1) << SIZE_W);          // R7
      p_total = (p_aw * p_ah * bps * spp) % (longint'(1) << SIZE_W);   // R8
   endtask

   // per-clock comparison of the held outputs against the model (R9)
   always @(negedge clk) begin
      if (rst_n && model_ok && !waiting && !busy) begin
         chk("R9", "held tile_split", tile_split, e_split);
         chk("R9", "held aligned_w", aligned_w, e_aw);
         chk("R9", "held aligned_h", aligned_h, e_ah);
         chk("R9", "held pitch", pitch, e_pitch);
         chk("R9", "held total_size", total_size, e_total);
      end
   end

   task automatic run_case(int w, int h, int bs, int sp, int pi, int ba, int bw, int bh, bit disturb);
      int lat;
      @(negedge clk);
      surf_w = DIM_W'(w); surf_h = DIM_W'(h);
      bps_lg = LF'(bs); spp_lg = LF'(sp); pipes_lg = LF'(pi);
      banks_lg = LF'(ba); bankw_lg = LF'(bw); bankh_lg = LF'(bh);
      predict(w, h, bs, sp, pi, ba, bw, bh);
      waiting = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      chk("R1", "busy after start", busy, 1);
      while (!done && lat < ALN_W + 6) begin
         if (disturb && lat == 3) begin
            // R10: a start while busy with other inputs must be ignored
            surf_w = DIM_W'(17); surf_h = DIM_W'(9); spp_lg = '0; bankh_lg = LF'(2);
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      chk("R1", "done seen", done, 1);
      chk("R1", "latency within bound", (lat <= ALN_W + 4) ? 1 : 0, 1);
      chk("R1", "busy low with done", busy, 0);
      e_split = p_split; e_asp = p_asp; e_mtw = p_mtw; e_mth = p_mth;
      e_aw = p_aw; e_ah = p_ah; e_pitch = p_pitch; e_total = p_total;
      model_ok = 1'b1;
      waiting = 1'b0;
      chk("R3", "tile_split", tile_split, e_split);
      chk("R4", "aspect_lg", aspect_lg, e_asp);
      chk("R5", "mtw_lg", mtw_lg, e_mtw);
      chk("R5", "mth_lg", mth_lg, e_mth);
      chk("R6", "aligned_w", aligned_w, e_aw);
      chk("R6", "aligned_h", aligned_h, e_ah);
      chk("R7", "pitch", pitch, e_pitch);
      chk("R8", "total_size", total_size, e_total);
      if (disturb) chk("R10", "busy start ignored (width)", aligned_w, e_aw);
      @(negedge clk);
      chk("R1", "done is one cycle", done, 0);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog expired actual 0 expected 1");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2: reset state
      chk("R2", "busy in reset", busy, 0);
      chk("R2", "done in reset", done, 0);
      chk("R2", "tile_split in reset", tile_split, 0);
      chk("R2", "total_size in reset", total_size, 0);
      chk("R2", "aligned_w in reset", aligned_w, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2", "pitch after reset", pitch, 0);

      // 8 samples, 4 bytes: split override, 1280x720 -> 1280x736, pitch 40960
      run_case(1280, 720, 2, 3, 1, 3, 0, 0, 1'b0);
      chk("R7", "8x multisample pitch", pitch, 40960);
      chk("R8", "8x multisample total", total_size, 30146560);
      // mask companion: 1 sample, default split
      run_case(1280, 736, 2, 0, 1, 3, 0, 0, 1'b0);
      chk("R8", "mask surface total", total_size, 3768320);
      // point-sampled, double bank height: 32x64 alignment
      run_case(1280, 720, 2, 0, 1, 3, 0, 1, 1'b0);
      chk("R6", "point-sampled aligned_h", aligned_h, 768);
      // micro-tile exactly 1024 bytes keeps default split
      run_case(640, 480, 2, 2, 1, 3, 0, 0, 1'b0);
      chk("R3", "1024-byte micro-tile split", tile_split, 1024);
      // more pipes than banks: aspect clamps to 0
      run_case(300, 200, 0, 1, 3, 1, 0, 0, 1'b0);
      chk("R4", "clamped aspect", aspect_lg, 0);
      // odd count: width and height differ by one
      run_case(100, 100, 1, 0, 0, 1, 0, 0, 1'b0);
      chk("R5", "odd count width", mtw_lg, 1);
      // 1x1 surface rounds up; busy start ignored
      run_case(1, 1, 3, 3, 1, 2, 1, 1, 1'b1);
      // R9: change inputs without start, outputs must hold
      @(negedge clk);
      surf_w = DIM_W'(4000); surf_h = DIM_W'(3000); bps_lg = '0; banks_lg = LF'(7);
      repeat (6) @(negedge clk);
      chk("R9", "total after input change", total_size, e_total);
      chk("R9", "mtw_lg after input change", mtw_lg, e_mtw);
      // large surface exercising wrap of the total
      run_case(16000, 12000, 3, 3, 1, 3, 0, 0, 1'b0);
      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule